// File: doc/BRIEF.md
# Command-Keyed Down-Counting Watchdog

This block is a system watchdog built around a down-counter that is wider than the bus word. Software controls it entirely through 16-bit command codes written to a control location. A command can halt the counter, restart it, acknowledge an expiry, open or close the count location for writing, or refill the counter to its maximum.

Reloads written to the count location are coarse. The written word fills the upper part of the counter and the low bits start at zero. A read of the count location returns the same upper slice. Servicing is a three-write sequence: open, write the count, close. A fast deliberate reset is obtained by halting, opening, writing 1, closing and resuming.

When a tick drives the counter to zero, a sticky expiry output rises and the counter rests at zero. The tick rate is set outside the block and arrives as a one-cycle enable. The write channel has a ready that is always high, so a write is taken in any cycle where valid is high. There is no back-pressure.

Top module: `cmd_key_watchdog`

## Requirements
- R1: After reset the counter holds its maximum value (readback 0xFFFF), counting is halted, the count location is closed, and `wdt_irq` is low.
- R2: Code 0x3877 written to control offset 0x00 halts counting, and code 0x4A4B resumes it. While halted, ticks leave the counter unchanged.
- R3: While the count location (offset 0x04) is open, a write there loads counter bits [19:4] with the data and bits [3:0] with zero. `wr_ready` is always high.
- R4: Code 0xAB00 opens the count location and code 0xAB01 closes it. A count write made while closed leaves the counter unchanged.
- R5: While counting is enabled, each cycle with `tick_en` high lowers the counter by exactly one. Cycles without a tick leave it unchanged.
- R6: The tick that takes the counter from 1 to 0 raises `wdt_irq` in the following cycle. The counter then holds at zero, and `wdt_irq` stays high until it is cleared.
- R7: Code 0x7482 clears `wdt_irq`. A counter that is already resting at zero does not raise it again.
- R8: Code 0xDEAF reloads the counter with all ones, whether the count location is open or closed.
- R9: Control words other than the six codes have no effect. Writes to any offset other than 0x00 and 0x04 have no effect. Cycles with `wr_valid` low have no effect.
- R10: `rd_data` returns counter bits [19:4] when `rd_addr` is 0x04, and zero for any other address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle count enable from the external tick source |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write accepted, always high |
| wr_addr | input | ADDR_W (8) | Byte offset of the write |
| wr_data | input | DATA_W (16) | Command code or count value |
| rd_addr | input | ADDR_W (8) | Byte offset of the read |
| rd_data | output | DATA_W (16) | Counter upper slice, or zero |
| wdt_irq | output | 1 | Sticky expiry indication |

## Verification
The bench builds the block with its default widths: a 20-bit counter, a 16-bit word and 8-bit offsets. The bench drives the tick directly, one enable per cycle. Loading small count words such as 1 and 2 brings the 1-to-0 transition within a few dozen ticks, so the exact expiry cycle and the zeroed low nibble can both be observed. The low nibble shows up as the readback stepping from 1 to 0 on the seventeenth tick after loading 2. The refill-to-maximum command is checked through the readback only, because counting down from 0xFFFFF would take about a million ticks.

// File: rtl/cmdwdg_pkg.sv
package cmdwdg_pkg;
  localparam int CMD_W = 16;
  localparam logic [CMD_W-1:0] CMD_HALT = 16'h3877;
  localparam logic [CMD_W-1:0] CMD_RUN  = 16'h4A4B;
  localparam logic [CMD_W-1:0] CMD_ACK  = 16'h7482;
  localparam logic [CMD_W-1:0] CMD_OPEN = 16'hAB00;
  localparam logic [CMD_W-1:0] CMD_SEAL = 16'hAB01;
  localparam logic [CMD_W-1:0] CMD_FILL = 16'hDEAF;

  typedef struct packed {
    logic halt;
    logic run;
    logic ack;
    logic open;
    logic seal;
    logic fill;
  } cmd_strobe_t;
endpackage

// File: rtl/cmdwdg_decode.sv
module cmdwdg_decode
  import cmdwdg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              hit_i,
  input  logic [DATA_W-1:0] code_i,
  output cmd_strobe_t       stb_o
);
  logic [CMD_W-1:0] code16;

  // Wider words only match when the bits above the code are zero.
  // 0x0000 is not a command, so it serves as the no-match value.
  generate
    if (DATA_W > CMD_W) begin : g_wide
      assign code16 = (code_i[DATA_W-1:CMD_W] == '0) ? code_i[CMD_W-1:0] : '0;
    end else begin : g_exact
      assign code16 = code_i;
    end
  endgenerate

  always_comb begin
    stb_o = '0;
    if (hit_i) begin
      case (code16)
        CMD_HALT: stb_o.halt = 1'b1;
        CMD_RUN:  stb_o.run  = 1'b1;
        CMD_ACK:  stb_o.ack  = 1'b1;
        CMD_OPEN: stb_o.open = 1'b1;
        CMD_SEAL: stb_o.seal = 1'b1;
        CMD_FILL: stb_o.fill = 1'b1;
        default:  stb_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/cmdwdg_ctrl.sv
module cmdwdg_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_i,
  input  logic run_i,
  input  logic ack_i,
  input  logic open_i,
  input  logic seal_i,
  input  logic expire_i,
  output logic running_o,
  output logic unlocked_o,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running_o  <= 1'b0;
      unlocked_o <= 1'b0;
      flag_o     <= 1'b0;
    end else begin
      if (halt_i)      running_o <= 1'b0;
      else if (run_i)  running_o <= 1'b1;

      if (open_i)      unlocked_o <= 1'b1;
      else if (seal_i) unlocked_o <= 1'b0;

      // An expiry in the same cycle as an acknowledge wins.
      if (expire_i)    flag_o <= 1'b1;
      else if (ack_i)  flag_o <= 1'b0;
    end
  end

  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> !running_o); // R2
  AST_SEAL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    seal_i |=> !unlocked_o); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && !ack_i |=> flag_o); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && !expire_i |=> !flag_o); // R7
endmodule

// File: rtl/cmdwdg_counter.sv
module cmdwdg_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step;
  assign step     = run_i && tick_i && !load_i;
  assign expire_o = step && (cnt_o == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt_o <= '1;
    else if (load_i)             cnt_o <= load_val_i;
    else if (step && cnt_o != 0) cnt_o <= cnt_o - ONE;
  end

  AST_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i && !(run_i && tick_i) |=> $stable(cnt_o)); // R2
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i && run_i && tick_i && cnt_o != '0 |=> cnt_o == $past(cnt_o) - ONE); // R5
  AST_ZERO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i && cnt_o == '0 |=> cnt_o == '0); // R6
endmodule

// File: rtl/cmd_key_watchdog.sv
module cmd_key_watchdog
  import cmdwdg_pkg::*;
#(
  parameter int CNT_W     = 20,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 8,
  parameter int CTRL_OFS  = 0,
  parameter int COUNT_OFS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              wdt_irq
);
  localparam int               VIEW_LSB = CNT_W - DATA_W;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(COUNT_OFS);

  logic        ctrl_hit, cnt_hit;
  logic        running, unlocked, expire;
  logic        load;
  logic [CNT_W-1:0] load_val, cnt;
  cmd_strobe_t stb;

  assign wr_ready = 1'b1;
  assign ctrl_hit = wr_valid && (wr_addr == A_CTRL);
  assign cnt_hit  = wr_valid && (wr_addr == A_COUNT);

  cmdwdg_decode #(.DATA_W(DATA_W)) dec_i (
    .hit_i (ctrl_hit),
    .code_i(wr_data),
    .stb_o (stb)
  );

  cmdwdg_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt_i    (stb.halt),
    .run_i     (stb.run),
    .ack_i     (stb.ack),
    .open_i    (stb.open),
    .seal_i    (stb.seal),
    .expire_i  (expire),
    .running_o (running),
    .unlocked_o(unlocked),
    .flag_o    (wdt_irq)
  );

  assign load     = stb.fill || (cnt_hit && unlocked);
  assign load_val = stb.fill ? '1 : {wr_data, {VIEW_LSB{1'b0}}};

  cmdwdg_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (running),
    .tick_i    (tick_en),
    .load_i    (load),
    .load_val_i(load_val),
    .cnt_o     (cnt),
    .expire_o  (expire)
  );

  assign rd_data = (rd_addr == A_COUNT) ? cnt[CNT_W-1:VIEW_LSB] : '0;

  AST_OPEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_hit && unlocked |=> cnt == {$past(wr_data), {VIEW_LSB{1'b0}}}); // R3
  AST_CLOSED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_hit && !unlocked && !(running && tick_en) |=> $stable(cnt)); // R4
  AST_FILL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    stb.fill |=> &cnt); // R8
  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb)); // R9
endmodule

// File: tb/cmd_key_watchdog_tb_top.sv
module cmd_key_watchdog_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  rd_addr = 8'h04;
  logic [15:0] rd_data;
  logic        wdt_irq;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  cmd_key_watchdog dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .wdt_irq(wdt_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
    end
    tick_en = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [15:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
    rd_addr = 8'h04;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    peek(8'h04, v); chk("R1 view", v, 16'hFFFF);
    chk("R1 irq", wdt_irq, 0);
    chk("R3 ready", wr_ready, 1);
    peek(8'h00, v); chk("R10 ctrl read", v, 0);
    ticks(3);
    peek(8'h04, v); chk("R1 halted", v, 16'hFFFF);
  endtask

  task automatic t_lock_ignore();
    logic [15:0] v;
    wr(8'h04, 16'h0005);
    peek(8'h04, v); chk("R4 closed write", v, 16'hFFFF);
  endtask

  task automatic t_load();
    logic [15:0] v;
    wr(8'h00, 16'hAB00); wr(8'h04, 16'h0002); wr(8'h00, 16'hAB01);
    peek(8'h04, v); chk("R3 load", v, 16'h0002);
    wr(8'h04, 16'h0009);
    peek(8'h04, v); chk("R4 after close", v, 16'h0002);
  endtask

  task automatic t_decrement();
    logic [15:0] v;
    wr(8'h00, 16'h4A4B);
    ticks(16);
    peek(8'h04, v); chk("R5 16 ticks", v, 16'h0001);
    wr(8'h00, 16'h3877);
    ticks(40);
    peek(8'h04, v); chk("R2 halted", v, 16'h0001);
    wr(8'h00, 16'h4A4B);
    @(negedge clk);
    peek(8'h04, v); chk("R5 no tick", v, 16'h0001);
    ticks(1);
    peek(8'h04, v); chk("R3 low nibble zero", v, 16'h0000);
  endtask

  task automatic t_expire();
    logic [15:0] v;
    ticks(14);
    chk("R6 not yet", wdt_irq, 0);
    ticks(1);
    chk("R6 expiry", wdt_irq, 1);
    ticks(5);
    peek(8'h04, v); chk("R6 hold zero", v, 0);
    chk("R6 sticky", wdt_irq, 1);
  endtask

  task automatic t_clear();
    logic [15:0] v;
    wr(8'h00, 16'h7482);
    chk("R7 cleared", wdt_irq, 0);
    ticks(5);
    chk("R7 no re-raise", wdt_irq, 0);
    peek(8'h04, v); chk("R7 still zero", v, 0);
  endtask

  task automatic t_max();
    logic [15:0] v;
    wr(8'h00, 16'hDEAF);
    peek(8'h04, v); chk("R8 fill while closed", v, 16'hFFFF);
    chk("R8 irq low", wdt_irq, 0);
  endtask

  task automatic t_unknown();
    logic [15:0] v;
    wr(8'h00, 16'h3877);
    wr(8'h00, 16'hAB00);
    wr(8'h00, 16'h4A4C);
    wr(8'h00, 16'hAB02);
    wr(8'h00, 16'h7483);
    ticks(3);
    peek(8'h04, v); chk("R9 unknown no run", v, 16'hFFFF);
    wr(8'h04, 16'h0030);
    peek(8'h04, v); chk("R9 still open", v, 16'h0030);
    wr(8'h08, 16'h0077);
    peek(8'h04, v); chk("R9 other offset", v, 16'h0030);
    wr_addr = 8'h04; wr_data = 16'h0055;
    @(negedge clk);
    peek(8'h04, v); chk("R9 valid low", v, 16'h0030);
  endtask

  task automatic t_restart();
    wr(8'h00, 16'h3877); wr(8'h00, 16'hAB00); wr(8'h04, 16'h0001);
    wr(8'h00, 16'hAB01); wr(8'h00, 16'h4A4B);
    ticks(15);
    chk("R6 restart before", wdt_irq, 0);
    ticks(1);
    chk("R6 restart expiry", wdt_irq, 1);
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock_ignore();
    t_load();
    t_decrement();
    t_expire();
    t_clear();
    t_max();
    t_unknown();
    t_restart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule